// File: doc/BRIEF.md
# Processor Bus Region Decoder with LED and Switch Ports

This block is the glue between a small 8-bit processor and its peripherals. It looks only at the upper three address lines and divides the 64 KB space into eight 8 KB regions, each announced on an active-low select. The topmost region's select goes straight to the ROM's active-low chip select, with no timing qualification.

Two simple ports sit in the space. The first is an 8-bit output latch that drives LEDs and is always visible. The second is an 8-bit switch input, which puts its value on the data bus only during a qualified read of its own region. Both port strobes are gated by the phase-2 clock. The output latch takes the write data when its strobe ends, because write data is valid only late in phase 2.

By default the read/write line plays no part in the strobes. A build-time option puts both ports at the output port's address, with read/write choosing the direction. The bidirectional data bus is split into an input bus, an output bus and an output-enable. A synchronous system clock samples phase 2 and the bus.

Top module: `bus_glue_top`

## Requirements
- R1: `region_sel_n[i]` is low exactly when `addr_hi` equals i (`addr_hi` carries A15..A13, A15 in bit 2). At all times exactly one select is low.
- R2: `rom_cs_n` is low exactly when `addr_hi` equals 7. It does not depend on `phi2` or `rw`.
- R3: `out_strobe` is high exactly when `addr_hi` equals 6 and `phi2` is high. In the default mode `rw` has no effect on it.
- R4: `led_out` takes the `data_in` value present on the last clock cycle in which `out_strobe` was high. The update lands on the clock edge at which `out_strobe` is first seen low. Before that edge `led_out` keeps its old value.
- R5: A synchronous active-high `rst` clears `led_out` to 8'h00.
- R6: Accesses to regions 0 to 5 and 7 leave `led_out` unchanged, whatever `rw` and `data_in` are.
- R7: In the default mode `in_strobe` is high exactly when `addr_hi` equals 5 and `phi2` is high, with `rw` ignored.
- R8: `data_oe` is high only for a read (`rw`=1, where 0 means write) of the input port's region while `phi2` is high. During that time `data_out` equals `sw_in`. At all other times `data_out` is 8'h00.
- R9: With `SHARED_PORT`=1 both ports live in region 6. `out_strobe` then also requires `rw`=0, while `in_strobe` and `data_oe` require `rw`=1. Region 5 fires no strobe and drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples phase 2 and the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 3 | Upper address lines A15..A13 |
| phi2 | input | 1 | Phase-2 bus clock, high during the data phase |
| rw | input | 1 | 1 = read, 0 = write |
| data_in | input | 8 | Data bus as driven by the processor |
| data_out | output | 8 | Switch data toward the data bus |
| data_oe | output | 1 | Drive enable for data_out onto the bus |
| sw_in | input | 8 | External switch inputs |
| led_out | output | 8 | Output latch toward the LED driver |
| region_sel_n | output | 8 | Active-low region selects |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| out_strobe | output | 1 | Qualified output-port strobe |
| in_strobe | output | 1 | Qualified input-port strobe |

## Verification
The bench drives the default build and the shared-address build side by side. It checks that the LEDs change only after the strobe ends, so a latch that captured on the leading edge would show new data one cycle early. A directed case changes the write data in the middle of a long phase 2, which exposes a latch that keeps the first value instead of the last. Reads of the output region and writes of the input region in both modes catch a design that ignores `rw` where it should not, or uses it where it should not; such a design fires a strobe in the wrong mode or drives the bus during a write. Accesses to every other region, and to the ROM region with `phi2` low, catch stray strobes and a ROM select that was wrongly gated by phase 2.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

    typedef enum logic {
        BUS_WRITE = 1'b0,
        BUS_READ  = 1'b1
    } bus_dir_e;

    typedef struct packed {
        logic out_stb;
        logic in_stb;
        logic drive;
    } port_ctl_t;

    // A strobe fires when its region is selected, phase 2 is high and
    // the direction condition (if any) is satisfied.
    function automatic logic qualify(input logic sel, input logic phi2, input logic dir_ok);
        return sel & phi2 & dir_ok;
    endfunction

endpackage

// File: rtl/region_decoder.sv
module region_decoder #(
    parameter int REGION_BITS = 3,
    localparam int NUM_REGIONS = 1 << REGION_BITS
) (
    input  logic [REGION_BITS-1:0] region,
    output logic [NUM_REGIONS-1:0] sel_n
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
        localparam logic [REGION_BITS-1:0] IDX = i;
        assign sel_n[i] = (region != IDX);
    end
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
    import bus_glue_pkg::*;
#(
    parameter bit SHARED_PORT = 1'b0
) (
    input  logic      sel_out,
    input  logic      sel_in,
    input  logic      phi2,
    input  logic      rw,
    output port_ctl_t ctl
);
    logic wr_ok;
    logic rd_ok;

    if (SHARED_PORT) begin : g_shared
        assign wr_ok = (rw == BUS_WRITE);
        assign rd_ok = (rw == BUS_READ);
    end else begin : g_split
        assign wr_ok = 1'b1;
        assign rd_ok = 1'b1;
    end

    always_comb begin
        ctl.out_stb = qualify(sel_out, phi2, wr_ok);
        ctl.in_stb  = qualify(sel_in, phi2, rd_ok);
        ctl.drive   = qualify(sel_in, phi2, rw == BUS_READ);
    end
endmodule

// File: rtl/led_latch.sv
module led_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] shadow;
    logic              stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            stb_q  <= 1'b0;
            q      <= '0;
        end else begin
            stb_q <= stb;
            if (stb)
                shadow <= data_in;
            if (stb_q && !stb)
                q <= shadow;
        end
    end
endmodule

// File: rtl/switch_drive.sv
module switch_drive #(
    parameter int DATA_W = 8
) (
    input  logic              drive,
    input  logic [DATA_W-1:0] sw_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    assign data_oe  = drive;
    assign data_out = drive ? sw_in : '0;
endmodule

// File: rtl/bus_glue_top.sv
module bus_glue_top
    import bus_glue_pkg::*;
#(
    parameter int REGION_BITS = 3,
    parameter int DATA_W      = 8,
    parameter int ROM_REGION  = 7,
    parameter int OUT_REGION  = 6,
    parameter int IN_REGION   = 5,
    parameter bit SHARED_PORT = 1'b0,
    localparam int NUM_REGIONS = 1 << REGION_BITS,
    localparam int IN_SLOT     = SHARED_PORT ? OUT_REGION : IN_REGION
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [REGION_BITS-1:0] addr_hi,
    input  logic                   phi2,
    input  logic                   rw,
    input  logic [DATA_W-1:0]      data_in,
    output logic [DATA_W-1:0]      data_out,
    output logic                   data_oe,
    input  logic [DATA_W-1:0]      sw_in,
    output logic [DATA_W-1:0]      led_out,
    output logic [NUM_REGIONS-1:0] region_sel_n,
    output logic                   rom_cs_n,
    output logic                   out_strobe,
    output logic                   in_strobe
);
    port_ctl_t ctl;

    region_decoder #(.REGION_BITS(REGION_BITS)) u_dec (
        .region (addr_hi),
        .sel_n  (region_sel_n)
    );

    assign rom_cs_n = region_sel_n[ROM_REGION];

    port_ctrl #(.SHARED_PORT(SHARED_PORT)) u_ctrl (
        .sel_out (!region_sel_n[OUT_REGION]),
        .sel_in  (!region_sel_n[IN_SLOT]),
        .phi2    (phi2),
        .rw      (rw),
        .ctl     (ctl)
    );

    assign out_strobe = ctl.out_stb;
    assign in_strobe  = ctl.in_stb;

    led_latch #(.DATA_W(DATA_W)) u_led (
        .clk     (clk),
        .rst     (rst),
        .stb     (ctl.out_stb),
        .data_in (data_in),
        .q       (led_out)
    );

    switch_drive #(.DATA_W(DATA_W)) u_sw (
        .drive    (ctl.drive),
        .sw_in    (sw_in),
        .data_out (data_out),
        .data_oe  (data_oe)
    );
endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk #(
    parameter int REGION_BITS = 3,
    parameter int DATA_W      = 8,
    parameter int ROM_REGION  = 7,
    parameter int OUT_REGION  = 6,
    parameter int IN_SLOT     = 5,
    localparam int NUM_REGIONS = 1 << REGION_BITS
) (
    input logic                   clk,
    input logic                   rst,
    input logic [REGION_BITS-1:0] addr_hi,
    input logic                   phi2,
    input logic                   rw,
    input logic [DATA_W-1:0]      data_out,
    input logic                   data_oe,
    input logic [DATA_W-1:0]      led_out,
    input logic [NUM_REGIONS-1:0] region_sel_n,
    input logic                   rom_cs_n,
    input logic                   out_strobe,
    input logic                   in_strobe
);
    AST_SINGLE_REGION: assert property (@(posedge clk) disable iff (rst)
        $countones(~region_sel_n) == 1); // R1

    AST_ROM_FOLLOWS_TOP: assert property (@(posedge clk) disable iff (rst)
        rom_cs_n == (int'(addr_hi) != ROM_REGION)); // R2

    AST_OUT_STROBE_QUAL: assert property (@(posedge clk) disable iff (rst)
        out_strobe |-> (phi2 && int'(addr_hi) == OUT_REGION)); // R3

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !($past(out_strobe) && !out_strobe) |=> $stable(led_out)); // R4

    AST_IN_STROBE_QUAL: assert property (@(posedge clk) disable iff (rst)
        in_strobe |-> (phi2 && int'(addr_hi) == IN_SLOT)); // R7

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (rw && phi2 && int'(addr_hi) == IN_SLOT)); // R8

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0)); // R8

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_strobe && in_strobe)); // R9
endmodule

bind bus_glue_top bus_glue_chk #(
    .REGION_BITS (REGION_BITS),
    .DATA_W      (DATA_W),
    .ROM_REGION  (ROM_REGION),
    .OUT_REGION  (OUT_REGION),
    .IN_SLOT     (IN_SLOT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_hi      (addr_hi),
    .phi2         (phi2),
    .rw           (rw),
    .data_out     (data_out),
    .data_oe      (data_oe),
    .led_out      (led_out),
    .region_sel_n (region_sel_n),
    .rom_cs_n     (rom_cs_n),
    .out_strobe   (out_strobe),
    .in_strobe    (in_strobe)
);

// File: tb/bus_glue_top_tb_top.sv
module bus_glue_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr_hi = 3'd0;
    logic       phi2 = 1'b0;
    logic       rw = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic [7:0] sw_in = 8'h00;

    logic [7:0] a_dout, b_dout, a_led, b_led, a_sel, b_sel;
    logic       a_oe, b_oe, a_rom, b_rom, a_os, b_os, a_is, b_is;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_led_a = 8'h00;
    logic [7:0] exp_led_b = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_glue_top dut_i (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .phi2(phi2), .rw(rw),
        .data_in(data_in), .data_out(a_dout), .data_oe(a_oe), .sw_in(sw_in),
        .led_out(a_led), .region_sel_n(a_sel), .rom_cs_n(a_rom),
        .out_strobe(a_os), .in_strobe(a_is)
    );

    bus_glue_top #(.SHARED_PORT(1'b1)) dut_sh_i (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .phi2(phi2), .rw(rw),
        .data_in(data_in), .data_out(b_dout), .data_oe(b_oe), .sw_in(sw_in),
        .led_out(b_led), .region_sel_n(b_sel), .rom_cs_n(b_rom),
        .out_strobe(b_os), .in_strobe(b_is)
    );

    function automatic logic f_out_stb(bit sh, logic [2:0] a, logic r, logic p);
        return p && a == 3'd6 && (!sh || !r);
    endfunction
    function automatic logic f_in_stb(bit sh, logic [2:0] a, logic r, logic p);
        return p && a == (sh ? 3'd6 : 3'd5) && (!sh || r);
    endfunction
    function automatic logic f_oe(bit sh, logic [2:0] a, logic r, logic p);
        return p && r && a == (sh ? 3'd6 : 3'd5);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_comb();
        logic eo;
        check("R1 sel A", a_sel, ~(8'h01 << addr_hi));
        check("R1 sel B", b_sel, ~(8'h01 << addr_hi));
        check("R2 rom A", {7'd0, a_rom}, {7'd0, addr_hi != 3'd7});
        check("R2 rom B", {7'd0, b_rom}, {7'd0, addr_hi != 3'd7});
        check("R3 out_strobe A", {7'd0, a_os}, {7'd0, f_out_stb(0, addr_hi, rw, phi2)});
        check("R9 out_strobe B", {7'd0, b_os}, {7'd0, f_out_stb(1, addr_hi, rw, phi2)});
        check("R7 in_strobe A", {7'd0, a_is}, {7'd0, f_in_stb(0, addr_hi, rw, phi2)});
        check("R9 in_strobe B", {7'd0, b_is}, {7'd0, f_in_stb(1, addr_hi, rw, phi2)});
        eo = f_oe(0, addr_hi, rw, phi2);
        check("R8 oe A", {7'd0, a_oe}, {7'd0, eo});
        check("R8 dout A", a_dout, eo ? sw_in : 8'h00);
        eo = f_oe(1, addr_hi, rw, phi2);
        check("R9 oe B", {7'd0, b_oe}, {7'd0, eo});
        check("R9 dout B", b_dout, eo ? sw_in : 8'h00);
    endtask

    // One bus access: phase 2 high for `hold` cycles, then low.
    task automatic access(input logic [2:0] a, input logic r, input logic [7:0] d,
                          input logic [7:0] d_late, input logic [7:0] sw, input int hold);
        logic [7:0] last_d;
        @(negedge clk);
        addr_hi = a; rw = r; data_in = d; sw_in = sw; phi2 = 1'b1;
        last_d = d;
        #1 check_comb();
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            data_in = d_late; last_d = d_late;
            #1 check_comb();
        end
        @(negedge clk);
        phi2 = 1'b0;
        #1 check_comb();
        check("R4 no early update A", a_led, exp_led_a);
        check("R4 no early update B", b_led, exp_led_b);
        if (f_out_stb(0, a, r, 1'b1)) exp_led_a = last_d;
        if (f_out_stb(1, a, r, 1'b1)) exp_led_b = last_d;
        @(negedge clk);
        #1;
        check("R4/R6 led A", a_led, exp_led_a);
        check("R4/R6 led B", b_led, exp_led_b);
    endtask

    bit done = 1'b0;
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BAD5EED));
        repeat (3) @(negedge clk);
        #1;
        check("R5 reset A", a_led, 8'h00);
        check("R5 reset B", b_led, 8'h00);
        rst = 1'b0;

        // Directed corners
        access(3'd6, 1'b0, 8'h3C, 8'h3C, 8'h11, 1);   // R3 write both
        access(3'd6, 1'b1, 8'hC3, 8'hC3, 8'h22, 1);   // R9 read at 6: A latches, B reads
        access(3'd5, 1'b0, 8'h77, 8'h77, 8'h5A, 1);   // R7 write to input region
        access(3'd5, 1'b1, 8'h88, 8'h88, 8'hA5, 1);   // R8 read input
        access(3'd7, 1'b1, 8'h99, 8'h99, 8'h0F, 2);   // R2, R6
        access(3'd0, 1'b0, 8'hEE, 8'hEE, 8'hF0, 1);   // R6
        access(3'd6, 1'b0, 8'h12, 8'hED, 8'h00, 3);   // R4 last data wins

        // Reset clears a nonzero latch
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R5 reset clears A", a_led, 8'h00);
        check("R5 reset clears B", b_led, 8'h00);
        exp_led_a = 8'h00; exp_led_b = 8'h00;
        rst = 1'b0;

        // Constrained random, biased toward the port and ROM regions
        for (int n = 0; n < 300; n++) begin
            logic [2:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            a = (pick < 3) ? 3'd6 : (pick < 5) ? 3'd5 : (pick < 6) ? 3'd7 : 3'($urandom_range(0, 7));
            access(a, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom),
                   8'($urandom), $urandom_range(1, 3));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule